// File: doc/BRIEF.md
# Codec Calibration and Valid-Data Sequencer

This block sequences the digital side of an audio codec through reset, power-down and offset calibration. It counts time in sample frames, not clock cycles. Each time the codec leaves reset or power-down, and each time the sample rate changes, the block starts a calibration window of a fixed number of frames. During that window it mutes the DAC path and forces the ADC words to zero. Once calibration ends, it waits a further number of frames equal to the configured digital-filter latency. Only then does it raise the ADC valid-data flag that travels with the serial output stream.

The block also produces a register-clear strobe while reset is held, which the control registers use. It watches how long the active-low reset was held, in clock cycles derived from a configured clock rate and minimum hold time in milliseconds. It raises an error flag when reset is released too early. The block treats every reset pulse as one that must meet this minimum.

Top module: `codec_cal_seq`

## Requirements
- R1: While rst_ni is low, reg_clr_o is 1 and cal_busy_o, dac_mute_o, adc_zero_o and adc_valid_o are 0. reg_clr_o stays 1 until the first rising clock edge after rst_ni goes high.
- R2: A calibration starts on release of reset. From the first rising edge after release, cal_busy_o, dac_mute_o and adc_zero_o are 1 and adc_valid_o is 0.
- R3: A calibration ends on the accepted frame strobe number CAL_FRAMES (194 by default), counted from its start. After 193 strobes cal_busy_o is still 1; after the 194th it is 0.
- R4: adc_zero_o and dac_mute_o are 1 for the whole calibration and fall together with cal_busy_o. adc_valid_o is 0 throughout.
- R5: filt_lat_i is an unsigned frame count L, sampled on the strobe that ends calibration. adc_valid_o rises one edge after the L-th accepted strobe that follows. With L = 0 it rises on the same edge on which cal_busy_o falls.
- R6: A rate-change strobe (rate_chg_i high for a cycle with pdn_i low) starts a new calibration from any state, including mid-calibration. By the next cycle cal_busy_o is 1 and adc_valid_o is 0, and the frame count restarts from zero.
- R7: When rate_chg_i and frame_i are high in the same cycle, the rate change wins and that frame strobe is not counted. The new calibration still needs a full 194 strobes.
- R8: Only cycles with frame_i high advance the frame count. Any number of idle cycles between strobes leaves the count unchanged.
- R9: While pdn_i is high, the block is powered down. adc_valid_o and cal_busy_o are 0, dac_mute_o and adc_zero_o are 1 from the next cycle, and frame and rate-change strobes are ignored.
- R10: On the first edge at which pdn_i is sampled low after a power-down, a new calibration starts from zero. It is followed by the latency wait, as after reset.
- R11: hold_err_o is set by the second rising edge after rst_ni rises if fewer than CLK_KHZ*HOLD_MS rising edges saw rst_ni low, and is cleared otherwise. It is cleared by the second rising edge after rst_ni falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pdn_i | input | 1 | Power-down request, level |
| frame_i | input | 1 | One-cycle sample-frame strobe |
| rate_chg_i | input | 1 | One-cycle sample-rate-change strobe |
| filt_lat_i | input | LAT_W | Digital-filter latency in frames |
| cal_busy_o | output | 1 | Calibration in progress |
| dac_mute_o | output | 1 | DAC outputs muted |
| adc_zero_o | output | 1 | ADC output words forced to zero |
| adc_valid_o | output | 1 | ADC data valid flag |
| reg_clr_o | output | 1 | Control-register clear |
| hold_err_o | output | 1 | Reset released before the minimum hold time |

## Verification
A frame strobe and a rate-change strobe can land in the same cycle. The clash matters most when the strobe would be the last frame of a calibration. The bench provokes this by driving both inputs together right after the 193rd frame. It then judges the result: cal_busy_o must stay high through another 193 strobes and fall only on the 194th. This shows that the restart cleared the count and swallowed the colliding frame, rather than ending calibration or counting the strobe into the new window.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [1:0] {
    ST_CAL    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2,
    ST_PDN    = 2'd3
  } cal_state_e;
endpackage

// File: rtl/ccs_frame_ctr.sv
module ccs_frame_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             at_end_o
);
  logic [CNT_W-1:0] cnt_q;

  assign at_end_o = (cnt_q == target_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= at_end_o ? '0 : cnt_q + CNT_W'(1);
  end

  AST_CNT_BELOW_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_i != '0) |-> (cnt_q < target_i)); // R3

  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/ccs_hold_mon.sv
module ccs_hold_mon #(
  parameter int CLK_KHZ = 250000,
  parameter int HOLD_MS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic hold_err_o
);
  localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;
  localparam int HW       = $clog2(HOLD_CYC + 1);

  logic          smp_q, prev_q, err_q;
  logic [HW-1:0] cnt_q;

  // reset is observed here as data; these flops must keep counting while it is low
  always_ff @(posedge clk_i) begin
    smp_q  <= rst_ni;
    prev_q <= smp_q;
    if (!smp_q) begin
      err_q <= 1'b0;
      if (prev_q)                      cnt_q <= HW'(1);
      else if (cnt_q != HW'(HOLD_CYC)) cnt_q <= cnt_q + HW'(1);
    end else if (!prev_q) begin
      err_q <= (cnt_q < HW'(HOLD_CYC));
    end
  end

  assign hold_err_o = err_q;
endmodule

// File: rtl/ccs_seq_fsm.sv
module ccs_seq_fsm
  import ccs_pkg::*;
#(
  parameter int CAL_FRAMES = 194,
  parameter int LAT_W      = 8,
  parameter int CNT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pdn_i,
  input  logic             frame_i,
  input  logic             rate_chg_i,
  input  logic [LAT_W-1:0] filt_lat_i,
  input  logic             ctr_end_i,
  output logic             ctr_step_o,
  output logic             ctr_clr_o,
  output logic [CNT_W-1:0] ctr_target_o,
  output logic             cal_busy_o,
  output logic             dac_mute_o,
  output logic             adc_zero_o,
  output logic             adc_valid_o,
  output logic             reg_clr_o
);
  cal_state_e       state_q, state_d;
  logic             clr_q;
  logic             lat_ld;
  logic [CNT_W-1:0] lat_q;

  always_comb begin
    state_d    = state_q;
    ctr_clr_o  = 1'b0;
    ctr_step_o = 1'b0;
    lat_ld     = 1'b0;
    if (pdn_i) begin
      state_d   = ST_PDN;
      ctr_clr_o = 1'b1;
    end else if (state_q == ST_PDN) begin
      state_d   = ST_CAL;
      ctr_clr_o = 1'b1;
    end else if (rate_chg_i) begin
      // restart wins over a coincident frame strobe
      state_d   = ST_CAL;
      ctr_clr_o = 1'b1;
    end else if (frame_i) begin
      unique case (state_q)
        ST_CAL: begin
          ctr_step_o = 1'b1;
          if (ctr_end_i) begin
            lat_ld    = 1'b1;
            ctr_clr_o = 1'b1;
            state_d   = (filt_lat_i == '0) ? ST_RUN : ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          ctr_step_o = 1'b1;
          if (ctr_end_i) begin
            ctr_clr_o = 1'b1;
            state_d   = ST_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CAL;
      clr_q   <= 1'b1;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      clr_q   <= 1'b0;
      if (lat_ld) lat_q <= CNT_W'(filt_lat_i);
    end
  end

  assign ctr_target_o = (state_q == ST_SETTLE) ? lat_q : CNT_W'(CAL_FRAMES);

  // status is held low for the whole reset window
  assign reg_clr_o   = clr_q;
  assign cal_busy_o  = !clr_q && (state_q == ST_CAL);
  assign dac_mute_o  = !clr_q && (state_q == ST_CAL || state_q == ST_PDN);
  assign adc_zero_o  = !clr_q && (state_q == ST_CAL || state_q == ST_PDN);
  assign adc_valid_o = !clr_q && (state_q == ST_RUN);

  AST_VALID_EXCLUDES_CAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_valid_o |-> (!cal_busy_o && !adc_zero_o && !dac_mute_o)); // R4

  AST_VALID_RISES_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_valid_o) |-> $past(frame_i)); // R5

  AST_RATE_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_chg_i && !pdn_i) |=> (cal_busy_o && !adc_valid_o)); // R6

  AST_PDN_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> (!adc_valid_o && !cal_busy_o && dac_mute_o && adc_zero_o)); // R9

  AST_PDN_EXIT_CAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PDN && !pdn_i) |=> cal_busy_o); // R10
endmodule

// File: rtl/codec_cal_seq.sv
module codec_cal_seq #(
  parameter int CAL_FRAMES = 194,
  parameter int LAT_W      = 8,
  parameter int CLK_KHZ    = 250000,
  parameter int HOLD_MS    = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pdn_i,
  input  logic             frame_i,
  input  logic             rate_chg_i,
  input  logic [LAT_W-1:0] filt_lat_i,
  output logic             cal_busy_o,
  output logic             dac_mute_o,
  output logic             adc_zero_o,
  output logic             adc_valid_o,
  output logic             reg_clr_o,
  output logic             hold_err_o
);
  localparam int CAL_W = $clog2(CAL_FRAMES + 1);
  localparam int CNT_W = (CAL_W > LAT_W) ? CAL_W : LAT_W;

  logic             ctr_step, ctr_clr, ctr_end;
  logic [CNT_W-1:0] ctr_target;

  ccs_seq_fsm #(
    .CAL_FRAMES(CAL_FRAMES),
    .LAT_W     (LAT_W),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pdn_i       (pdn_i),
    .frame_i     (frame_i),
    .rate_chg_i  (rate_chg_i),
    .filt_lat_i  (filt_lat_i),
    .ctr_end_i   (ctr_end),
    .ctr_step_o  (ctr_step),
    .ctr_clr_o   (ctr_clr),
    .ctr_target_o(ctr_target),
    .cal_busy_o  (cal_busy_o),
    .dac_mute_o  (dac_mute_o),
    .adc_zero_o  (adc_zero_o),
    .adc_valid_o (adc_valid_o),
    .reg_clr_o   (reg_clr_o)
  );

  ccs_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ctr_clr),
    .step_i  (ctr_step),
    .target_i(ctr_target),
    .at_end_o(ctr_end)
  );

  ccs_hold_mon #(
    .CLK_KHZ(CLK_KHZ),
    .HOLD_MS(HOLD_MS)
  ) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_err_o(hold_err_o)
  );
endmodule

// File: tb/codec_cal_seq_tb.sv
module codec_cal_seq_tb;
  localparam int LAT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pdn_i = 1'b0;
  logic             frame_i = 1'b0;
  logic             rate_chg_i = 1'b0;
  logic [LAT_W-1:0] filt_lat_i = 8'd5;
  logic             cal_busy_o, dac_mute_o, adc_zero_o, adc_valid_o, reg_clr_o, hold_err_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  // hold minimum = 100 kHz-equivalent * 1 ms = 100 edges
  codec_cal_seq #(
    .CAL_FRAMES(194),
    .LAT_W     (LAT_W),
    .CLK_KHZ   (100),
    .HOLD_MS   (1)
  ) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pdn_i      (pdn_i),
    .frame_i    (frame_i),
    .rate_chg_i (rate_chg_i),
    .filt_lat_i (filt_lat_i),
    .cal_busy_o (cal_busy_o),
    .dac_mute_o (dac_mute_o),
    .adc_zero_o (adc_zero_o),
    .adc_valid_o(adc_valid_o),
    .reg_clr_o  (reg_clr_o),
    .hold_err_o (hold_err_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic busy, input logic mute,
                           input logic zero, input logic valid);
    check(req, "cal_busy_o", cal_busy_o, busy);
    check(req, "dac_mute_o", dac_mute_o, mute);
    check(req, "adc_zero_o", adc_zero_o, zero);
    check(req, "adc_valid_o", adc_valid_o, valid);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic frames(input int n);
    repeat (n) begin
      @(negedge clk_i) frame_i = 1'b1;
      @(negedge clk_i) frame_i = 1'b0;
    end
  endtask

  task automatic rate_pulse();
    @(negedge clk_i) rate_chg_i = 1'b1;
    @(negedge clk_i) rate_chg_i = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  task automatic t_power_on();
    idle(150);
    check("R1", "reg_clr_o", reg_clr_o, 1'b1);
    check_out("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    #1 check("R1", "reg_clr_o before edge", reg_clr_o, 1'b1);
    idle(1);
    check("R1", "reg_clr_o after edge", reg_clr_o, 1'b0);
    check_out("R2", 1'b1, 1'b1, 1'b1, 1'b0);
    idle(1);
    check("R11", "hold_err_o long hold", hold_err_o, 1'b0);
  endtask

  task automatic t_cal_len();
    filt_lat_i = 8'd5;
    frames(193);
    check_out("R3", 1'b1, 1'b1, 1'b1, 1'b0);
    frames(1);
    check_out("R4", 1'b0, 1'b0, 1'b0, 1'b0);
    frames(4);
    check("R5", "valid after 4 of 5", adc_valid_o, 1'b0);
    frames(1);
    check("R5", "valid after 5 of 5", adc_valid_o, 1'b1);
  endtask

  task automatic t_lat_zero();
    filt_lat_i = 8'd0;
    rate_pulse();
    check_out("R6", 1'b1, 1'b1, 1'b1, 1'b0);
    frames(194);
    check_out("R5", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_rate_mid();
    rate_pulse();
    frames(100);
    rate_pulse();
    check("R6", "busy after mid restart", cal_busy_o, 1'b1);
    frames(193);
    check("R6", "busy 193 after restart", cal_busy_o, 1'b1);
    frames(1);
    check_out("R6", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_collide();
    rate_pulse();
    frames(193);
    @(negedge clk_i) begin frame_i = 1'b1; rate_chg_i = 1'b1; end
    @(negedge clk_i) begin frame_i = 1'b0; rate_chg_i = 1'b0; end
    check("R7", "busy after collision", cal_busy_o, 1'b1);
    frames(193);
    check("R7", "busy 193 after collision", cal_busy_o, 1'b1);
    frames(1);
    check_out("R7", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_gaps();
    rate_pulse();
    frames(190);
    idle(300);
    check("R8", "busy after idle gap", cal_busy_o, 1'b1);
    frames(3);
    check("R8", "busy after 193", cal_busy_o, 1'b1);
    frames(1);
    check("R8", "busy after 194", cal_busy_o, 1'b0);
  endtask

  task automatic t_pdn();
    filt_lat_i = 8'd3;
    @(negedge clk_i) pdn_i = 1'b1;
    @(negedge clk_i);
    check_out("R9", 1'b0, 1'b1, 1'b1, 1'b0);
    frames(200);
    rate_pulse();
    check_out("R9", 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk_i) pdn_i = 1'b0;
    @(negedge clk_i);
    check_out("R10", 1'b1, 1'b1, 1'b1, 1'b0);
    frames(194);
    check_out("R10", 1'b0, 1'b0, 1'b0, 1'b0);
    frames(2);
    check("R10", "valid after 2 of 3", adc_valid_o, 1'b0);
    frames(1);
    check("R10", "valid after 3 of 3", adc_valid_o, 1'b1);
  endtask

  task automatic t_hold();
    @(negedge clk_i) rst_ni = 1'b0;
    idle(50);
    check("R1", "reg_clr_o in reset", reg_clr_o, 1'b1);
    check("R1", "adc_valid_o in reset", adc_valid_o, 1'b0);
    rst_ni = 1'b1;
    idle(2);
    check("R11", "hold_err_o short hold", hold_err_o, 1'b1);
    check("R2", "cal_busy_o after release", cal_busy_o, 1'b1);
    rst_ni = 1'b0;
    idle(2);
    check("R11", "hold_err_o cleared in reset", hold_err_o, 1'b0);
    idle(148);
    rst_ni = 1'b1;
    idle(2);
    check("R11", "hold_err_o long hold", hold_err_o, 1'b0);
  endtask

  initial begin
    t_power_on();
    t_cal_len();
    t_lat_zero();
    t_rate_mid();
    t_collide();
    t_gaps();
    t_pdn();
    t_hold();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule